// File: doc/BRIEF.md
# Five-Port Mesh Router with Relative Hop Addressing

This block is one router tile of a two-dimensional mesh network-on-chip. It has four neighbour lanes (north, east, south, west) and one local lane that faces the attached IP. Every lane has a receive side and a send side. Each side carries a data-valid bit, a header-marker bit and a flit, and a stall bit runs back to the sender. A packet is one header flit followed by zero or more payload flits. The header holds the destination as two signed hop counts. The router reduces the count of the dimension it forwards along, so the tile where both counts reach zero delivers the packet to its local lane.

Routing is fixed. The vertical offset is used up first and only then the horizontal offset. Each receive lane has a small buffer. Each send lane has an arbiter and a one-flit output register. When a header wins a send lane, that lane stays reserved for the winning input until the input shows a new header or its buffer runs empty. Packets therefore never mix on one link. The sender of each packet must present its flits back to back, holding data-valid while stalled.

Lane numbering is shared by all packed port vectors: 0 local, 1 north, 2 east, 3 south, 4 west. Lane i occupies bit i of the one-bit vectors and bits [i*FLIT_W +: FLIT_W] of the flit vectors.

Top module: `mesh_router`

## Requirements
- R1: During reset and in the first cycle after it, every out_da bit is 0 and every in_stall bit is 0.
- R2: A header has its vertical hop count in bits [2*HOP_W-1:HOP_W] and its horizontal hop count in bits [HOP_W-1:0], both two's complement, and the header is the flit sent with av=1. If the vertical count is positive, the header leaves on lane 1 (north) with that count reduced by 1. If it is negative, the header leaves on lane 3 (south) with the count raised by 1. All other header bits leave unchanged.
- R3: If the vertical count is zero and the horizontal count is positive, the header leaves on lane 2 (east) with the horizontal count reduced by 1. If the vertical count is zero and the horizontal count is negative, it leaves on lane 4 (west) with the horizontal count raised by 1.
- R4: If both counts are zero, the header leaves on lane 0 (local) unchanged.
- R5: The payload flits (av=0) of a packet leave on the same lane as its header, unchanged, in order, with av=0. Each flit appears exactly once and on no other lane.
- R6: When two or more headers compete in the same cycle for a free send lane, the input with the lowest lane number wins. The order from highest to lowest priority is local, north, east, south, west.
- R7: Once a header has been granted a send lane, every remaining flit of that packet leaves on that lane before any flit of another input.
- R8: While out_da and out_stall of a lane are both 1, out_da, out_av and out_data of that lane hold their values into the next cycle.
- R9: A receive lane raises in_stall when its BUF_DEPTH-flit buffer is full. A flit offered while in_stall is 1 is not taken, and no offered flit is lost or duplicated.
- R10: A send lane's reservation ends when the owning input presents a new header or its buffer runs empty. A later packet from another input then gets the lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_da | input | 5 | Per receive lane: a flit is offered |
| in_av | input | 5 | Per receive lane: the offered flit is a header |
| in_data | input | 5*FLIT_W | Per receive lane: the offered flit |
| in_stall | output | 5 | Per receive lane: buffer full, sender must hold |
| out_da | output | 5 | Per send lane: a flit is presented |
| out_av | output | 5 | Per send lane: the presented flit is a header |
| out_data | output | 5*FLIT_W | Per send lane: the presented flit |
| out_stall | input | 5 | Per send lane: the receiver refuses the flit |

## Verification
The bench builds the router with FLIT_W=32, HOP_W=8 and BUF_DEPTH=2. With a two-flit buffer, holding one send lane stalled for a few cycles fills the competing receive buffers and raises in_stall. This makes the buffer-full back-pressure and the hold of the output register reachable within a handful of cycles. With eight-bit hop fields the bench can use negative offsets and offsets that reach zero on this tile. Together these cover every routing direction and the delivery to the local lane.

// File: rtl/mrt_pkg.sv
// Shared definitions for the mesh router tile.
// Lane numbers double as arbitration priority: a lower number wins.
package mrt_pkg;
    localparam int NP = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;
endpackage

// File: rtl/mrt_in_fifo.sv
// Receive buffer for one lane: a small circular FIFO.
// Assumes: the consumer pops only a visible head. full drives the upstream
// stall straight from the occupancy register, so a pop in the same cycle
// does not clear it (this is a conservative choice).
module mrt_in_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_vld,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         head_vld,
    output logic [W-1:0] head_data,
    input  logic         pop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (cnt == CW'(DEPTH));
    assign do_push   = push_vld && !full;
    assign head_vld  = (cnt != '0);
    assign head_data = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (pop)     rd_ptr <= nxt(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(pop);
        end
    end

    // Storage write; the data needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_vld);
endmodule

// File: rtl/mrt_route.sv
// Route computation for one header: vertical first, then horizontal.
// Assumes: two signed hop fields sit at the bottom of the flit, with the
// vertical field above the horizontal one. Positive means north or east.
module mrt_route
    import mrt_pkg::*;
#(
    parameter int FLIT_W = 32,
    parameter int HOP_W  = 8
) (
    input  logic [FLIT_W-1:0] hdr,
    output port_e             dir,
    output logic [FLIT_W-1:0] hdr_next
);
    localparam logic signed [HOP_W-1:0] ONE = 1;

    logic signed [HOP_W-1:0] v, h;

    // Pick the lane and reduce the hop count that is being travelled.
    always_comb begin
        v        = hdr[2*HOP_W-1:HOP_W];
        h        = hdr[HOP_W-1:0];
        hdr_next = hdr;
        dir      = P_LOCAL;
        if (v > 0) begin
            dir = P_NORTH;
            hdr_next[2*HOP_W-1:HOP_W] = v - ONE;
        end else if (v < 0) begin
            dir = P_SOUTH;
            hdr_next[2*HOP_W-1:HOP_W] = v + ONE;
        end else if (h > 0) begin
            dir = P_EAST;
            hdr_next[HOP_W-1:0] = h - ONE;
        end else if (h < 0) begin
            dir = P_WEST;
            hdr_next[HOP_W-1:0] = h + ONE;
        end
    end
endmodule

// File: rtl/mrt_out_port.sv
// Send lane: fixed-priority arbiter with a wormhole reservation, and a
// one-flit output register that holds its flit while stalled.
// Assumes: each input requests at most one lane. A payload request only
// comes from an input that earlier won this lane with a header.
module mrt_out_port #(
    parameter int NIN = 5,
    parameter int W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIN-1:0]   req,
    input  logic [NIN-1:0]   hdr,
    input  logic [NIN-1:0]   vld,
    input  logic [NIN*W-1:0] cand_data,
    input  logic             stall,
    output logic [NIN-1:0]   grant,
    output logic             o_vld,
    output logic             o_av,
    output logic [W-1:0]     o_data
);
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;

    logic          locked;
    logic [IW-1:0] owner;
    logic [IW-1:0] sel;
    logic          any, ready, free;

    // Choose the input that moves into the output register this cycle.
    always_comb begin
        ready = !o_vld || !stall;
        free  = !locked || !vld[owner] || hdr[owner];
        any   = 1'b0;
        sel   = owner;
        if (ready) begin
            if (free) begin
                for (int i = NIN - 1; i >= 0; i--) begin
                    if (req[i] && hdr[i]) begin
                        any = 1'b1;
                        sel = IW'(i);
                    end
                end
            end else if (req[owner]) begin
                any = 1'b1;
            end
        end
        grant = any ? (NIN'(1) << sel) : '0;
    end

    // Take or keep the wormhole reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= '0;
        end else if (any) begin
            locked <= 1'b1;
            owner  <= sel;
        end else if (free) begin
            locked <= 1'b0;
        end
    end

    // Output register: load on a grant, empty when the flit is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_av   <= 1'b0;
            o_data <= '0;
        end else if (any) begin
            o_vld  <= 1'b1;
            o_av   <= hdr[sel];
            o_data <= cand_data[sel*W +: W];
        end else if (!stall) begin
            o_vld  <= 1'b0;
        end
    end

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !o_vld);
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && stall) |=> (o_vld && $stable(o_data) && $stable(o_av)));
    p_payload_from_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & ~hdr)) |-> (locked && grant[owner]));
    p_lock_stick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && vld[owner] && !hdr[owner]) |=> (locked && $stable(owner)));
endmodule

// File: rtl/mesh_router.sv
// Five-lane mesh router tile (lanes: 0 local, 1 N, 2 E, 3 S, 4 W).
// Each receive lane has a buffer, a route unit and a register that keeps
// the lane chosen by its last header. Each send lane has an arbiter and an
// output register.
// Assumes: FLIT_W >= 2*HOP_W, BUF_DEPTH >= 1, and senders keep the flits
// of a packet back to back.
module mesh_router
    import mrt_pkg::*;
#(
    parameter int FLIT_W    = 32,
    parameter int HOP_W     = 8,
    parameter int BUF_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        in_da,
    input  logic [NP-1:0]        in_av,
    input  logic [NP*FLIT_W-1:0] in_data,
    output logic [NP-1:0]        in_stall,
    output logic [NP-1:0]        out_da,
    output logic [NP-1:0]        out_av,
    output logic [NP*FLIT_W-1:0] out_data,
    input  logic [NP-1:0]        out_stall
);
    localparam int EW = FLIT_W + 1;

    logic [NP-1:0]        head_vld, head_av, pop;
    logic [FLIT_W-1:0]    head_data [NP];
    port_e                eff_dir   [NP];
    logic [NP*FLIT_W-1:0] cand_flat;
    logic [NP-1:0]        req       [NP];
    logic [NP-1:0]        gnt       [NP];

    for (genvar gi = 0; gi < NP; gi++) begin : g_in
        logic [EW-1:0]     hd;
        logic [FLIT_W-1:0] hnext;
        port_e             rdir, dir_q;

        mrt_in_fifo #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_vld  (in_da[gi]),
            .push_data ({in_av[gi], in_data[gi*FLIT_W +: FLIT_W]}),
            .full      (in_stall[gi]),
            .head_vld  (head_vld[gi]),
            .head_data (hd),
            .pop       (pop[gi])
        );

        assign head_av[gi]   = hd[EW-1];
        assign head_data[gi] = hd[FLIT_W-1:0];

        mrt_route #(.FLIT_W(FLIT_W), .HOP_W(HOP_W)) u_rt (
            .hdr      (head_data[gi]),
            .dir      (rdir),
            .hdr_next (hnext)
        );

        // Remember where the current packet goes, for its payload flits.
        always_ff @(posedge clk) begin
            if (!rst_n)                    dir_q <= P_LOCAL;
            else if (pop[gi] && head_av[gi]) dir_q <= rdir;
        end

        assign eff_dir[gi] = head_av[gi] ? rdir : dir_q;
        assign cand_flat[gi*FLIT_W +: FLIT_W] = head_av[gi] ? hnext : head_data[gi];
    end

    // Turn each head's lane into request vectors, and grants into pops.
    always_comb begin
        pop = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req[o][i] = head_vld[i] && (eff_dir[i] == port_e'(3'(o)));
            end
            pop = pop | gnt[o];
        end
    end

    for (genvar go = 0; go < NP; go++) begin : g_out
        mrt_out_port #(.NIN(NP), .W(FLIT_W)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req[go]),
            .hdr       (head_av),
            .vld       (head_vld),
            .cand_data (cand_flat),
            .stall     (out_stall[go]),
            .grant     (gnt[go]),
            .o_vld     (out_da[go]),
            .o_av      (out_av[go]),
            .o_data    (out_data[go*FLIT_W +: FLIT_W])
        );
    end
endmodule

// File: tb/mesh_router_tb_top.sv
// Self-checking bench for mesh_router: a table of single-packet vectors,
// then directed tests for reset, priority, stalls, release and all-lane load.
module mesh_router_tb_top;
    localparam int W  = 32;
    localparam int NP = 5;
    localparam int CAP = 128;

    // Vector: src, v, h, payload count, expected lane, expected v, expected h
    localparam logic [41:0] VEC [8] = '{
        {3'd0, 8'h02, 8'h03, 4'd2, 3'd1, 8'h01, 8'h03},
        {3'd2, 8'hFF, 8'h05, 4'd3, 3'd3, 8'h00, 8'h05},
        {3'd4, 8'h00, 8'h04, 4'd1, 3'd2, 8'h00, 8'h03},
        {3'd1, 8'h00, 8'hFE, 4'd0, 3'd4, 8'h00, 8'hFF},
        {3'd3, 8'h00, 8'h00, 4'd2, 3'd0, 8'h00, 8'h00},
        {3'd0, 8'h00, 8'h01, 4'd4, 3'd2, 8'h00, 8'h00},
        {3'd1, 8'hFD, 8'hFD, 4'd1, 3'd3, 8'hFE, 8'hFD},
        {3'd4, 8'h01, 8'h00, 4'd3, 3'd1, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]   in_da, in_av, in_stall, out_da, out_av, out_stall;
    logic [NP*W-1:0] in_data, out_data;

    logic          drv_da   [NP];
    logic          drv_av   [NP];
    logic [W-1:0]  drv_data [NP];
    logic [NP-1:0] stall_force = '0;
    logic [NP-1:0] rnd = '0;
    logic          rand_en = 1'b0;

    logic [W:0] cap [NP][CAP];
    int         cap_n [NP];
    int         base  [NP];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    mesh_router #(.FLIT_W(W), .HOP_W(8), .BUF_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_da(in_da), .in_av(in_av), .in_data(in_data),
        .in_stall(in_stall), .out_da(out_da), .out_av(out_av), .out_data(out_data),
        .out_stall(out_stall)
    );

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_da[i] = drv_da[i];
            in_av[i] = drv_av[i];
            in_data[i*W +: W] = drv_data[i];
        end
        out_stall = stall_force | (rand_en ? rnd : '0);
    end

    always begin
        @(posedge clk);
        #1 rnd = NP'($urandom);
    end

    // Record every flit the receiver accepts at the coming edge.
    initial begin
        for (int o = 0; o < NP; o++) cap_n[o] = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int o = 0; o < NP; o++) begin
                    if (out_da[o] && !out_stall[o]) begin
                        if (cap_n[o] < CAP) cap[o][cap_n[o]] = {out_av[o], out_data[o*W +: W]};
                        cap_n[o]++;
                    end
                end
            end
        end
    end

    function automatic logic [W-1:0] hdr_word(input logic [7:0] v, input logic [7:0] h);
        return {16'hC3C3, v, h};
    endfunction

    function automatic logic [W-1:0] pay_word(input int src, input int id, input int k);
        return {4'(src), 12'(id), 16'(k)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Offer one packet on lane src, honouring in_stall.
    task automatic send_pkt(input int src, input int id, input logic [7:0] v,
                            input logic [7:0] h, input int len);
        for (int k = 0; k <= len; k++) begin
            bit took = 1'b0;
            drv_da[src]   = 1'b1;
            drv_av[src]   = (k == 0);
            drv_data[src] = (k == 0) ? hdr_word(v, h) : pay_word(src, id, k - 1);
            while (!took) begin
                @(negedge clk);
                took = !in_stall[src];
                @(posedge clk);
                #1;
            end
        end
        drv_da[src] = 1'b0;
        drv_av[src] = 1'b0;
    endtask

    task automatic snap();
        for (int o = 0; o < NP; o++) base[o] = cap_n[o];
    endtask

    task automatic drain();
        repeat (30) @(posedge clk);
        rand_en = 1'b0;
        repeat (12) @(posedge clk);
        #1;
    endtask

    // Compare one captured packet at lane dst, starting at capture index at.
    task automatic chk_pkt(input int dst, input int at, input int src, input int id,
                           input logic [7:0] ev, input logic [7:0] eh, input int len,
                           input string rq);
        logic [W:0] exp;
        exp = {1'b1, hdr_word(ev, eh)};
        chk(cap[dst][at] == exp, rq, 64'(cap[dst][at]), 64'(exp));
        for (int k = 0; k < len; k++) begin
            exp = {1'b0, pay_word(src, id, k)};
            chk(cap[dst][at + 1 + k] == exp, "R5", 64'(cap[dst][at + 1 + k]), 64'(exp));
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        for (int i = 0; i < NP; i++) begin
            drv_da[i] = 1'b0; drv_av[i] = 1'b0; drv_data[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        // R1: quiet outputs during reset and just after its release
        chk(out_da == '0, "R1", 64'(out_da), 64'(0));
        chk(in_stall == '0, "R1", 64'(in_stall), 64'(0));
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(out_da == '0, "R1", 64'(out_da), 64'(0));
        chk(in_stall == '0, "R1", 64'(in_stall), 64'(0));

        // Table walk: one packet per vector, random stalls on odd entries.
        for (int e = 0; e < 8; e++) begin
            int src, len, dst;
            logic [7:0] v, h, ev, eh;
            string rq;
            src = int'(VEC[e][41:39]); v = VEC[e][38:31]; h = VEC[e][30:23];
            len = int'(VEC[e][22:19]); dst = int'(VEC[e][18:16]);
            ev = VEC[e][15:8]; eh = VEC[e][7:0];
            rq = (dst == 1 || dst == 3) ? "R2" : ((dst == 0) ? "R4" : "R3");
            snap();
            rand_en = e[0];
            send_pkt(src, 16 + e, v, h, len);
            drain();
            for (int o = 0; o < NP; o++) begin
                int exp_n;
                exp_n = (o == dst) ? len + 1 : 0;
                chk(cap_n[o] - base[o] == exp_n, "R5", 64'(cap_n[o] - base[o]), 64'(exp_n));
            end
            chk_pkt(dst, base[dst], src, 16 + e, ev, eh, len, rq);
        end

        // R6/R7/R8/R9: north and west headers contend for a stalled east lane.
        snap();
        stall_force[2] = 1'b1;
        fork
            send_pkt(1, 40, 8'h00, 8'h01, 3);
            send_pkt(4, 41, 8'h00, 8'h02, 3);
            begin
                repeat (3) @(posedge clk);
                #1;
                held = out_data[2*W +: W];
                chk(out_da[2] && out_av[2], "R8", 64'({out_da[2], out_av[2]}), 64'(3));
                chk(held == hdr_word(8'h00, 8'h00), "R6", 64'(held), 64'(hdr_word(8'h00, 8'h00)));
                repeat (3) @(posedge clk);
                #1;
                chk(out_data[2*W +: W] == held && out_da[2], "R8", 64'(out_data[2*W +: W]), 64'(held));
                chk(in_stall[1] && in_stall[4], "R9", 64'(in_stall), 64'(5'b10010));
                stall_force[2] = 1'b0;
            end
        join
        drain();
        chk(cap_n[2] - base[2] == 8, "R9", 64'(cap_n[2] - base[2]), 64'(8));
        chk_pkt(2, base[2], 1, 40, 8'h00, 8'h00, 3, "R6");
        chk_pkt(2, base[2] + 4, 4, 41, 8'h00, 8'h01, 3, "R7");

        // R10: north sends to east, then at once to south; west then takes east.
        snap();
        send_pkt(1, 50, 8'h00, 8'h01, 2);
        send_pkt(1, 51, 8'hFF, 8'h00, 1);
        send_pkt(4, 52, 8'h00, 8'h01, 1);
        drain();
        chk(cap_n[2] - base[2] == 5, "R10", 64'(cap_n[2] - base[2]), 64'(5));
        chk_pkt(2, base[2], 1, 50, 8'h00, 8'h00, 2, "R3");
        chk_pkt(2, base[2] + 3, 4, 52, 8'h00, 8'h00, 1, "R10");
        chk(cap_n[3] - base[3] == 2, "R10", 64'(cap_n[3] - base[3]), 64'(2));
        chk_pkt(3, base[3], 1, 51, 8'h00, 8'h00, 1, "R2");

        // All five lanes inject together under random send-side stalls.
        snap();
        rand_en = 1'b1;
        fork
            send_pkt(0, 60, 8'h01, 8'h00, 3);
            send_pkt(1, 61, 8'hFF, 8'h02, 3);
            send_pkt(2, 62, 8'h00, 8'hFF, 3);
            send_pkt(3, 63, 8'h00, 8'h03, 3);
            send_pkt(4, 64, 8'h00, 8'h00, 3);
        join
        drain();
        for (int o = 0; o < NP; o++) begin
            chk(cap_n[o] - base[o] == 4, "R5", 64'(cap_n[o] - base[o]), 64'(4));
        end
        chk_pkt(1, base[1], 0, 60, 8'h00, 8'h00, 3, "R2");
        chk_pkt(3, base[3], 1, 61, 8'h00, 8'h02, 3, "R2");
        chk_pkt(4, base[4], 2, 62, 8'h00, 8'h00, 3, "R3");
        chk_pkt(2, base[2], 3, 63, 8'h00, 8'h02, 3, "R3");
        chk_pkt(0, base[0], 4, 64, 8'h00, 8'h00, 3, "R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule